// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is the byte-wide exchange point between a host bus and an embedded keyboard-controller core. The host reaches it through two ports: a data port and a command port. A host write to either port drops one byte into the input buffer for the core. A host read of the data port takes the byte the core left in the output buffer. A single status byte is shared by both sides and combines hardware handshake flags with bits the core firmware may set freely.

The status byte carries three hardware-managed flags. The output-full flag means a byte is waiting for the host. The input-full flag means a byte is waiting for the core. The command/data flag records which host port delivered the last byte. The remaining status bits belong to the core. The input-full flag is also driven out as an interrupt to the core. A host interrupt line is raised when output data is waiting and the core has enabled that interrupt.

Top module: `kbc_mailbox`

## Requirements
- R1: After reset the status byte is all zero (no user bits set), both buffers are zero, `host_irq` and `core_ibf_irq` are low, and the host interrupt enable is off.
- R2: A core data write (`core_wr_data`) loads the output buffer. From the next cycle `host_rdata` shows that byte and status bit 0 (output full) is 1.
- R3: A host read of the data port (`host_rd_data`) with no core data write in the same cycle clears status bit 0 at the next cycle.
- R4: A host write to the data port loads the input buffer and sets status bit 1 (input full), and clears status bit 3 (command/data) to 0. A byte already waiting is overwritten.
- R5: A host write to the command port loads the input buffer, sets status bit 1, and sets status bit 3 to 1. If both host write strobes are active together, the command port wins.
- R6: A core data read (`core_rd_data`) with no host write in the same cycle clears status bit 1 at the next cycle and leaves bit 3 and `core_rdata` unchanged.
- R7: A core status write (`core_wr_status`) changes only bits 2 and 7..4. Bits 0, 1 and 3 keep their hardware values, and the user bits hold their value when no status write occurs.
- R8: `host_irq` equals status bit 0 AND the host interrupt enable. The enable is written by `core_wr_irq_en` with value `core_irq_en`.
- R9: `core_ibf_irq` equals status bit 1.
- R10: When a host write and a core data read happen in the same cycle, the input-full flag stays 1 and the input buffer holds the new byte.
- R11: When a core data write and a host data-port read happen in the same cycle, the output-full flag stays 1 and the output buffer holds the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_data | input | 1 | Host write strobe, data port |
| host_wr_cmd | input | 1 | Host write strobe, command port |
| host_wdata | input | 8 | Host write byte |
| host_rd_data | input | 1 | Host read strobe, data port |
| host_rdata | output | 8 | Output buffer as seen by host |
| core_wr_data | input | 1 | Core write strobe, data register |
| core_wdata | input | 8 | Core write byte (data or status) |
| core_rd_data | input | 1 | Core read strobe, data register |
| core_rdata | output | 8 | Input buffer as seen by core |
| core_wr_status | input | 1 | Core write strobe, status user bits |
| core_wr_irq_en | input | 1 | Core write strobe, host interrupt enable |
| core_irq_en | input | 1 | New host interrupt enable value |
| mbox_status | output | 8 | Shared status byte |
| host_irq | output | 1 | Host interrupt: output data waiting |
| core_ibf_irq | output | 1 | Core interrupt: input data waiting |

## Verification
The bench targets the same-cycle collisions. If the design let a clear win over a set, a host byte arriving while the core drains the previous one would be lost, and a core byte written while the host reads would never be flagged. It checks that a status write with every bit set leaves the handshake flags intact. A design that failed to mask them would fake or drop a full flag. It also checks that the command/data flag follows the last port used and survives the core's read. A design that cleared it on read would mislabel a command as data.

// File: rtl/kbc_mbox_pkg.sv
package kbc_mbox_pkg;
   localparam int unsigned OBF_POS = 0;
   localparam int unsigned IBF_POS = 1;
   localparam int unsigned CD_POS  = 3;

   typedef enum logic {
      SRC_DATA = 1'b0,
      SRC_CMD  = 1'b1
   } src_port_e;
endpackage

// File: rtl/kbc_in_buf.sv
module kbc_in_buf
   import kbc_mbox_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_data,
   input  logic          wr_cmd,
   input  logic [DW-1:0] wdata,
   input  logic          rd,
   output logic [DW-1:0] buf_q,
   output logic          full_q,
   output logic          cd_q
);
   logic      any_wr;
   src_port_e src;

   assign any_wr = wr_data | wr_cmd;
   assign src    = wr_cmd ? SRC_CMD : SRC_DATA;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_q  <= '0;
         full_q <= 1'b0;
         cd_q   <= 1'b0;
      end else begin
         if (any_wr) begin
            buf_q  <= wdata;
            full_q <= 1'b1;
            cd_q   <= src;
         end else if (rd) begin
            full_q <= 1'b0;
         end
      end
   end

   AST_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      any_wr |=> full_q); // R4
   AST_CD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmd |=> cd_q); // R5
   AST_CD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && !wr_cmd) |=> !cd_q); // R4
   AST_IN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !any_wr) |=> (!full_q && $stable(cd_q) && $stable(buf_q))); // R6
endmodule

// File: rtl/kbc_out_buf.sv
module kbc_out_buf #(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   input  logic          rd,
   output logic [DW-1:0] buf_q,
   output logic          full_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_q  <= '0;
         full_q <= 1'b0;
      end else if (wr) begin
         buf_q  <= wdata;
         full_q <= 1'b1;
      end else if (rd) begin
         full_q <= 1'b0;
      end
   end

   AST_OUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (full_q && buf_q == $past(wdata))); // R2
   AST_OUT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !wr) |=> !full_q); // R3
endmodule

// File: rtl/kbc_status.sv
module kbc_status
   import kbc_mbox_pkg::*;
#(
   parameter int unsigned DW         = 8,
   parameter logic        IRQ_EN_RST = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_status,
   input  logic [DW-1:0] wdata,
   input  logic          wr_irq_en,
   input  logic          irq_en_d,
   input  logic          obf,
   input  logic          ibf,
   input  logic          cd,
   output logic [DW-1:0] status,
   output logic          irq_en_q
);
   logic [DW-1:0] user_mask;
   logic [DW-1:0] user_q;
   logic [DW-1:0] hw_bits;

   for (genvar b = 0; b < DW; b++) begin : g_mask
      if (b == OBF_POS || b == IBF_POS || b == CD_POS) begin : g_hw
         assign user_mask[b] = 1'b0;
      end else begin : g_user
         assign user_mask[b] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         user_q   <= '0;
         irq_en_q <= IRQ_EN_RST;
      end else begin
         if (wr_status) user_q <= wdata & user_mask;
         if (wr_irq_en) irq_en_q <= irq_en_d;
      end
   end

   always_comb begin
      hw_bits          = '0;
      hw_bits[OBF_POS] = obf;
      hw_bits[IBF_POS] = ibf;
      hw_bits[CD_POS]  = cd;
   end

   assign status = (user_q & user_mask) | hw_bits;

   AST_USER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_status |=> $stable(status & user_mask)); // R7
   AST_HW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (status[OBF_POS] == obf) && (status[IBF_POS] == ibf) && (status[CD_POS] == cd)); // R7
endmodule

// File: rtl/kbc_mailbox.sv
module kbc_mailbox
   import kbc_mbox_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter logic        IRQ_EN_RST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr_data,
   input  logic              host_wr_cmd,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              host_rd_data,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              core_wr_data,
   input  logic [DATA_W-1:0] core_wdata,
   input  logic              core_rd_data,
   output logic [DATA_W-1:0] core_rdata,
   input  logic              core_wr_status,
   input  logic              core_wr_irq_en,
   input  logic              core_irq_en,
   output logic [DATA_W-1:0] mbox_status,
   output logic              host_irq,
   output logic              core_ibf_irq
);
   localparam int unsigned MIN_W = CD_POS + 1;

   initial begin
      if (DATA_W < MIN_W)
         $error("kbc_mailbox: DATA_W must be at least %0d", MIN_W);
   end

   logic obf, ibf, cd, irq_en;

   kbc_in_buf #(.DW(DATA_W)) u_in (
      .clk(clk), .rst_n(rst_n),
      .wr_data(host_wr_data), .wr_cmd(host_wr_cmd), .wdata(host_wdata),
      .rd(core_rd_data),
      .buf_q(core_rdata), .full_q(ibf), .cd_q(cd)
   );

   kbc_out_buf #(.DW(DATA_W)) u_out (
      .clk(clk), .rst_n(rst_n),
      .wr(core_wr_data), .wdata(core_wdata), .rd(host_rd_data),
      .buf_q(host_rdata), .full_q(obf)
   );

   kbc_status #(.DW(DATA_W), .IRQ_EN_RST(IRQ_EN_RST)) u_stat (
      .clk(clk), .rst_n(rst_n),
      .wr_status(core_wr_status), .wdata(core_wdata),
      .wr_irq_en(core_wr_irq_en), .irq_en_d(core_irq_en),
      .obf(obf), .ibf(ibf), .cd(cd),
      .status(mbox_status), .irq_en_q(irq_en)
   );

   assign host_irq     = obf & irq_en;
   assign core_ibf_irq = ibf;

   AST_HIRQ_NEEDS_OBF: assert property (@(posedge clk) disable iff (!rst_n)
      host_irq |-> mbox_status[OBF_POS]); // R8
   AST_CIRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      core_ibf_irq == mbox_status[IBF_POS]); // R9
   AST_IN_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
      ((host_wr_data || host_wr_cmd) && core_rd_data) |=> core_ibf_irq); // R10
   AST_OUT_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (core_wr_data && host_rd_data) |=> mbox_status[OBF_POS]); // R11
endmodule

// File: tb/tb_kbc_mailbox.sv
module tb_kbc_mailbox;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hwd = 0, hwc = 0, hrd = 0, cwd = 0, crd = 0, cws = 0, cwe = 0, cen = 0;
   logic [7:0] hwdata = 0, cwdata = 0;
   logic [7:0] host_rdata, core_rdata, st;
   logic hirq, cirq;
   int checks = 0, errors = 0;

   always #2 clk = ~clk;

   kbc_mailbox dut (
      .clk(clk), .rst_n(rst_n),
      .host_wr_data(hwd), .host_wr_cmd(hwc), .host_wdata(hwdata),
      .host_rd_data(hrd), .host_rdata(host_rdata),
      .core_wr_data(cwd), .core_wdata(cwdata), .core_rd_data(crd),
      .core_rdata(core_rdata), .core_wr_status(cws),
      .core_wr_irq_en(cwe), .core_irq_en(cen),
      .mbox_status(st), .host_irq(hirq), .core_ibf_irq(cirq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      hwd = 0; hwc = 0; hrd = 0; cwd = 0; crd = 0; cws = 0; cwe = 0;
   endtask

   task automatic step();
      @(negedge clk);
      idle();
   endtask

   task automatic t_reset();
      chk("R1 status", st, 8'h00);
      chk("R1 irqs", {6'b0, hirq, cirq}, 8'h00);
      chk("R1 bufs", host_rdata | core_rdata, 8'h00);
   endtask

   task automatic t_core_to_host();
      cwd = 1; cwdata = 8'hA5; step();
      chk("R2 host_rdata", host_rdata, 8'hA5);
      chk("R2 obf", {7'b0, st[0]}, 8'h01);
      chk("R8 irq disabled", {7'b0, hirq}, 8'h00);
      cwe = 1; cen = 1; step();
      chk("R8 irq enabled", {7'b0, hirq}, 8'h01);
      hrd = 1; step();
      chk("R3 obf cleared", {7'b0, st[0]}, 8'h00);
      chk("R8 irq dropped", {7'b0, hirq}, 8'h00);
   endtask

   task automatic t_host_data();
      hwd = 1; hwdata = 8'h3C; step();
      chk("R4 core_rdata", core_rdata, 8'h3C);
      chk("R4 status", st, 8'h02);
      chk("R9 core irq", {7'b0, cirq}, 8'h01);
      hwd = 1; hwdata = 8'h44; step();
      chk("R4 overwrite", core_rdata, 8'h44);
      crd = 1; step();
      chk("R6 ibf cleared", st, 8'h00);
      chk("R6 data kept", core_rdata, 8'h44);
      chk("R9 core irq low", {7'b0, cirq}, 8'h00);
   endtask

   task automatic t_host_cmd();
      hwc = 1; hwdata = 8'hD4; step();
      chk("R5 status", st, 8'h0A);
      chk("R5 byte", core_rdata, 8'hD4);
      crd = 1; step();
      chk("R6 cd kept", st, 8'h08);
      hwd = 1; hwc = 1; hwdata = 8'h11; step();
      chk("R5 cmd wins", st, 8'h0A);
      hwd = 1; hwdata = 8'h22; step();
      chk("R4 cd cleared", st, 8'h02);
      crd = 1; step();
   endtask

   task automatic t_status();
      cws = 1; cwdata = 8'hFF; step();
      chk("R7 user only", st, 8'hF4);
      hwc = 1; hwdata = 8'h01; step();
      chk("R7 user held", st, 8'hFE);
      cws = 1; cwdata = 8'h0B; step();
      chk("R7 hw kept", st, 8'h0A);
      crd = 1; cws = 1; cwdata = 8'h00; step();
      chk("R7 cleared", st, 8'h08);
   endtask

   task automatic t_collide();
      hwd = 1; hwdata = 8'h55; step();
      hwd = 1; hwdata = 8'h66; crd = 1; step();
      chk("R10 ibf kept", {7'b0, st[1]}, 8'h01);
      chk("R10 new byte", core_rdata, 8'h66);
      crd = 1; step();
      cwd = 1; cwdata = 8'h77; step();
      cwd = 1; cwdata = 8'h88; hrd = 1; step();
      chk("R11 obf kept", {7'b0, st[0]}, 8'h01);
      chk("R11 new byte", host_rdata, 8'h88);
      chk("R8 irq with obf", {7'b0, hirq}, 8'h01);
      cwe = 1; cen = 0; step();
      chk("R8 irq masked", {7'b0, hirq}, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_core_to_host();
      t_host_data();
      t_host_cmd();
      t_status();
      t_collide();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #40000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule